// File: doc/BRIEF.md
# Control Endpoint OUT Stage Sequencer

This block follows a control transfer on endpoint zero in which the host sends data to the device. It covers the stage that carries the payload and the status stage that follows it. Packet reception is reduced to a one-cycle valid strobe. The strobe carries a byte count, a DATA0/DATA1 toggle bit and a flag that marks a SETUP token. Firmware acts on the block through four one-cycle strobes:

- release the held packet
- declare the data stage finished
- request a stall
- clear the stall report

The block keeps a packet-ready flag and a byte count that is visible only while that flag is set. It also keeps a stall-report flag, raises a one-cycle interrupt for firmware and a one-cycle NAK indication for the packet layer, and shows its current stage. The maximum packet size is a parameter that defaults to 32 bytes. Firmware finds the end of the data stage by noting a packet shorter than that size, which can be a zero-length packet.

Top module: `ep0_out_seq`

## Requirements
- R1: After reset, `stage` is 0 (idle), and `pkt_rdy`, `rx_count`, `sent_stall`, `ep_irq` and `nak` are all 0.
- R2: A SETUP packet (`pkt_valid` with `pkt_setup`=1) moves `stage` to 1 (data-out) from any stage and clears `pkt_rdy`, one cycle after the strobe.
- R3: A data packet (`pkt_valid` with `pkt_setup`=0) that arrives while `stage` is 0 or 3 has no effect: `pkt_rdy`, `ep_irq`, `nak` and `stage` are unchanged.
- R4: A data packet in stage 1 with `pkt_rdy`=0 sets `pkt_rdy`, latches `pkt_len` into `rx_count` and pulses `ep_irq` for exactly one cycle. This covers lengths from 0 up to `MAX_PKT`.
- R5: A data packet in stage 1 with `pkt_rdy`=1 is refused. `nak` pulses for one cycle, `rx_count` keeps its value and `ep_irq` stays 0.
- R6: `fw_clr_rdy` clears `pkt_rdy`. `rx_count` reads 0 whenever `pkt_rdy` is 0.
- R7: `fw_data_end` in stage 1 moves `stage` to 2 (status).
- R8: In stage 2, a zero-length DATA1 packet (`pkt_data1`=1) with no stall request pending returns `stage` to 0 without an interrupt.
- R9: In stage 2, the status stage fails if the packet is not zero length, is DATA0, or arrives while a stall request (from `fw_send_stall`) is pending. On failure `sent_stall` is set, `ep_irq` pulses and `stage` becomes 3 (halted).
- R10: `fw_clr_sent_stall` clears `sent_stall` and the pending stall request and returns `stage` to 0. After it, a correct status stage succeeds again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pkt_valid | input | 1 | One-cycle strobe: a packet was received |
| pkt_setup | input | 1 | The received packet follows a SETUP token |
| pkt_len | input | 6 | Payload byte count of the packet |
| pkt_data1 | input | 1 | Data toggle of the packet: 1 for DATA1 |
| fw_clr_rdy | input | 1 | Firmware strobe: packet unloaded |
| fw_data_end | input | 1 | Firmware strobe: last data packet handled |
| fw_send_stall | input | 1 | Firmware strobe: request a stall |
| fw_clr_sent_stall | input | 1 | Firmware strobe: clear the stall report |
| pkt_rdy | output | 1 | A received packet waits for firmware |
| rx_count | output | 6 | Byte count of the held packet, 0 when none |
| sent_stall | output | 1 | The status stage failed with a stall |
| ep_irq | output | 1 | One-cycle endpoint interrupt |
| nak | output | 1 | One-cycle refusal of a packet |
| stage | output | 2 | 0 idle, 1 data-out, 2 status, 3 halted |

## Verification
Every output is a register. Each result therefore appears one clock after the edge that samples its strobe, and the two pulses (`ep_irq`, `nak`) fall again one clock later. The bench changes inputs on falling edges and holds each strobe for exactly one cycle. It samples at the next falling edge, which lies half a period after the edge that captured the strobe. Pulse widths are checked again one cycle after that.

// File: rtl/ep0_out_seq.sv
module ep0_out_seq #(
  parameter int MAX_PKT = 32,
  localparam int LW = $clog2(MAX_PKT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pkt_valid,
  input  logic          pkt_setup,
  input  logic [LW-1:0] pkt_len,
  input  logic          pkt_data1,
  input  logic          fw_clr_rdy,
  input  logic          fw_data_end,
  input  logic          fw_send_stall,
  input  logic          fw_clr_sent_stall,
  output logic          pkt_rdy,
  output logic [LW-1:0] rx_count,
  output logic          sent_stall,
  output logic          ep_irq,
  output logic          nak,
  output logic [1:0]    stage
);

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_DATA = 2'd1, ST_STATUS = 2'd2, ST_HALT = 2'd3} st_t;

  st_t           st_q;
  logic          rdy_q, sent_q, stall_req_q, irq_q, nak_q;
  logic [LW-1:0] cnt_q;

  wire setup_in = pkt_valid & pkt_setup;
  wire data_in  = pkt_valid & ~pkt_setup;
  wire take     = data_in & (st_q == ST_DATA) & ~rdy_q;
  wire refuse   = data_in & (st_q == ST_DATA) & rdy_q;
  wire stat_in  = data_in & (st_q == ST_STATUS);
  wire stat_bad = stat_in & (stall_req_q | (pkt_len != '0) | ~pkt_data1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      rdy_q       <= 1'b0;
      cnt_q       <= '0;
      sent_q      <= 1'b0;
      stall_req_q <= 1'b0;
      irq_q       <= 1'b0;
      nak_q       <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      nak_q <= 1'b0;
      if (setup_in) begin
        st_q  <= ST_DATA;
        rdy_q <= 1'b0;
      end else if (fw_clr_sent_stall) begin
        sent_q      <= 1'b0;
        stall_req_q <= 1'b0;
        st_q        <= ST_IDLE;
      end else begin
        if (fw_send_stall) stall_req_q <= 1'b1;
        if (fw_clr_rdy)    rdy_q <= 1'b0;
        if (take) begin
          rdy_q <= 1'b1;
          cnt_q <= pkt_len;
          irq_q <= 1'b1;
        end
        if (refuse) nak_q <= 1'b1;
        if (st_q == ST_DATA && fw_data_end) st_q <= ST_STATUS;
        if (stat_in) begin
          if (stat_bad) begin
            sent_q <= 1'b1;
            irq_q  <= 1'b1;
            st_q   <= ST_HALT;
          end else begin
            st_q <= ST_IDLE;
          end
        end
      end
    end
  end

  assign pkt_rdy    = rdy_q;
  assign rx_count   = rdy_q ? cnt_q : '0;
  assign sent_stall = sent_q;
  assign ep_irq     = irq_q;
  assign nak        = nak_q;
  assign stage      = st_q;

  a_r2_setup_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    setup_in |=> (stage == 2'd1) && !pkt_rdy);

  a_r4_take_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (data_in && stage == 2'd1 && !pkt_rdy && !fw_clr_sent_stall) |=> pkt_rdy && ep_irq);

  a_r5_refuse_holds_count: assert property (@(posedge clk) disable iff (!rst_n)
    (data_in && stage == 2'd1 && pkt_rdy && !fw_clr_rdy && !fw_clr_sent_stall)
      |=> nak && !ep_irq && $stable(rx_count));

  a_r9_fail_reports: assert property (@(posedge clk) disable iff (!rst_n)
    (data_in && stage == 2'd2 && pkt_len != '0 && !fw_clr_sent_stall)
      |=> sent_stall && ep_irq && stage == 2'd3);

  a_r4_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ep_irq |=> !ep_irq);

  a_r5_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ep_irq, nak}));

endmodule

// File: tb/tb_ep0_out_seq.sv
module tb_ep0_out_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pkt_valid = 0, pkt_setup = 0, pkt_data1 = 0;
  logic [5:0] pkt_len = '0;
  logic fw_clr_rdy = 0, fw_data_end = 0, fw_send_stall = 0, fw_clr_sent_stall = 0;
  logic pkt_rdy, sent_stall, ep_irq, nak;
  logic [5:0] rx_count;
  logic [1:0] stage;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  ep0_out_seq dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pkt(input bit setup, input int len, input bit d1);
    @(negedge clk);
    pkt_valid = 1; pkt_setup = setup; pkt_len = 6'(len); pkt_data1 = d1;
    @(negedge clk);
    pkt_valid = 0; pkt_setup = 0; pkt_len = '0; pkt_data1 = 0;
  endtask

  task automatic fw(input int which);
    @(negedge clk);
    case (which)
      0: fw_clr_rdy = 1;
      1: fw_data_end = 1;
      2: fw_send_stall = 1;
      default: fw_clr_sent_stall = 1;
    endcase
    @(negedge clk);
    fw_clr_rdy = 0; fw_data_end = 0; fw_send_stall = 0; fw_clr_sent_stall = 0;
  endtask

  task automatic t_reset;
    chk("R1 stage", stage, 0); chk("R1 rdy", pkt_rdy, 0); chk("R1 count", rx_count, 0);
    chk("R1 stall", sent_stall, 0); chk("R1 irq", ep_irq, 0); chk("R1 nak", nak, 0);
  endtask

  task automatic t_idle_ignore;
    pkt(0, 7, 1);
    chk("R3 idle rdy", pkt_rdy, 0); chk("R3 idle irq", ep_irq, 0);
    chk("R3 idle nak", nak, 0); chk("R3 idle stage", stage, 0);
  endtask

  task automatic t_full_then_short;
    pkt(1, 8, 0);
    chk("R2 setup stage", stage, 1);
    pkt(0, 32, 1);
    chk("R4 rdy", pkt_rdy, 1); chk("R4 count", rx_count, 32); chk("R4 irq", ep_irq, 1);
    @(negedge clk);
    chk("R4 irq width", ep_irq, 0);
    pkt(0, 9, 0);
    chk("R5 nak", nak, 1); chk("R5 count kept", rx_count, 32); chk("R5 no irq", ep_irq, 0);
    fw(0);
    chk("R6 rdy clr", pkt_rdy, 0); chk("R6 count hidden", rx_count, 0);
    pkt(0, 5, 0);
    chk("R4 short count", rx_count, 5);
    fw(0);
    fw(1);
    chk("R7 status", stage, 2);
    pkt(0, 0, 1);
    chk("R8 idle", stage, 0); chk("R8 no irq", ep_irq, 0); chk("R8 no stall", sent_stall, 0);
  endtask

  task automatic t_zero_end_bad_len;
    pkt(1, 8, 0);
    pkt(0, 0, 1);
    chk("R4 zero rdy", pkt_rdy, 1); chk("R4 zero count", rx_count, 0);
    fw(0); fw(1);
    pkt(0, 3, 1);
    chk("R9 len stall", sent_stall, 1); chk("R9 len irq", ep_irq, 1); chk("R9 halted", stage, 3);
    pkt(0, 4, 1);
    chk("R3 halted rdy", pkt_rdy, 0); chk("R3 halted nak", nak, 0); chk("R3 halted irq", ep_irq, 0);
    fw(3);
    chk("R10 stall clr", sent_stall, 0); chk("R10 idle", stage, 0);
  endtask

  task automatic t_data0_status;
    pkt(1, 8, 0); pkt(0, 1, 0); fw(0); fw(1);
    pkt(0, 0, 0);
    chk("R9 data0 stall", sent_stall, 1); chk("R9 data0 stage", stage, 3);
    fw(3);
  endtask

  task automatic t_stall_request;
    pkt(1, 8, 0); pkt(0, 2, 0); fw(0); fw(2); fw(1);
    pkt(0, 0, 1);
    chk("R9 req stall", sent_stall, 1); chk("R9 req irq", ep_irq, 1);
    fw(3);
    pkt(1, 8, 0); pkt(0, 2, 0); fw(0); fw(1);
    pkt(0, 0, 1);
    chk("R10 req cleared", sent_stall, 0); chk("R10 ok stage", stage, 0);
  endtask

  task automatic t_setup_abort;
    pkt(1, 8, 0); pkt(0, 6, 0); fw(0); fw(1);
    chk("R7 in status", stage, 2);
    pkt(0, 0, 0);
    pkt(1, 8, 0);
    chk("R2 abort stage", stage, 1); chk("R2 abort rdy", pkt_rdy, 0);
    pkt(0, 11, 0);
    pkt(1, 8, 0);
    chk("R2 drop rdy", pkt_rdy, 0); chk("R2 stage again", stage, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_idle_ignore;
    t_full_then_short;
    t_zero_end_bad_len;
    t_data0_status;
    t_stall_request;
    t_setup_abort;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule